// File: doc/BRIEF.md
# Flow-through burst SRAM with zero-bubble turnaround

This block is a synchronous static memory of 32-bit words, each split into four byte lanes. A command and its address are registered on one rising clock edge. Read data leaves on the same cycle that follows that edge (flow-through). Write data and byte-lane selects follow one enabled edge later. Because of that offset, reads and writes can be mixed on every cycle with no idle cycle between them. An access can continue as a burst of up to four words. The burst sequence is built from the two low address bits, in a linear or an interleaved order chosen by a strap input.

An active-low clock enable freezes the whole block and stretches the current cycle. A sleep request, synchronised inside the block, parks it in a deselected state and keeps the memory contents. The bidirectional data bus is split into a write-data input, a read-data output and a drive-enable output. The drive-enable tells the surrounding logic when the block would drive the bus.

The output enable is asynchronous. It only gates the drive-enable, and the internal state can force the drive off whatever the output enable says.

Top module: `fsb_sram`

## Requirements
- R1: After synchronous reset the block is deselected and `rdata_oe` is 0. A burst-continue cycle (`burst_next`=1) issued while deselected is a continued deselect and leaves `rdata_oe` at 0.
- R2: A new access is accepted on a rising edge only when `clk_en_n`=0, `sel_a_n`=0, `sel_b`=1, `sel_c_n`=0, `burst_next`=0 and the block is awake. `wr_n`=0 makes it a write and `wr_n`=1 a read. With `burst_next`=0 and any select inactive, the edge deselects the block and `rdata_oe` is 0 after it.
- R3: For a write, `wdata` and `lane_wr_n` are taken on the next enabled edge after the command edge, and a new command may be given on that same edge. A read of the same address issued on that edge returns the newly written bytes.
- R4: After a read command edge, `rdata` holds the addressed word and `rdata_oe` is 1 (with `out_en_n`=0) until the next enabled edge.
- R5: With `clk_en_n`=0 and `burst_next`=1 after a read or write, the burst advances to the next location. Selects and `wr_n` are ignored on such an edge and the access type of the burst is kept. Address bits above bit 1 stay those of the start address, and the two low bits wrap after four beats.
- R6: With `order_ilv`=0, beat i of a burst uses low bits (start+i) mod 4. With `order_ilv`=1 it uses start XOR i.
- R7: `lane_wr_n[b]`=0 writes bits [8b+7:8b]. Lanes whose select is 1 keep their contents. A write beat with all four selects at 1 writes nothing, yet the burst still advances past it.
- R8: While `clk_en_n`=1 the edge is ignored. No write is performed, all state is held, `rdata` and `rdata_oe` keep their values, and a pending write data phase waits for the next enabled edge.
- R9: `rdata_oe` is 0 during the data phase of a write, while deselected, and whenever `out_en_n`=1. The output enable acts at once, without waiting for a clock edge.
- R10: `sleep_req` passes through two flip-flops. Once it has been high before an edge e0, edges from e0+2 on ignore commands and `rdata_oe` is 0 from e0+1. Memory contents are kept. After `sleep_req` falls the block is deselected, and it accepts commands again two edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en_n | input | 1 | Active-low clock qualifier; high freezes the block |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| burst_next | input | 1 | 0 loads a new command, 1 continues the burst |
| wr_n | input | 1 | 0 write, 1 read, sampled on a load edge |
| lane_wr_n | input | 4 | Active-low write select per byte lane |
| addr | input | ADDR_W | Word address, sampled on a load edge |
| wdata | input | DATA_W | Write data, taken one enabled edge after its command |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| order_ilv | input | 1 | Burst order strap: 0 linear, 1 interleaved |
| sleep_req | input | 1 | Asynchronous sleep request, active high |
| rdata | output | DATA_W | Read data word |
| rdata_oe | output | 1 | High when the block would drive the data bus |

## Verification
On every cycle, the embedded assertions check these rules:
- A frozen edge changes no command state.
- Sleep always returns the control to the deselected state.
- The burst start address stays fixed while a burst advances.
- The drive is never on during a write data phase.
- Reset leaves the control idle.

Other behaviours are shown only by the bench's directed and random scenarios against its reference model:
- the beat order in both modes and the wrap of the low address bits;
- byte-lane merging and aborted beats;
- forwarding of a write into the read that follows it directly;
- the two-edge sleep latency and the data kept through sleep;
- the immediate effect of the output enable.

// File: rtl/fsb_pkg.sv
package fsb_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } fsb_op_e;

  // Low address bits of a burst beat, for either sequence order.
  function automatic logic [1:0] beat_offset(input logic [1:0] start,
                                             input logic [1:0] beat,
                                             input logic       interleave);
    return interleave ? (start ^ beat) : (start + beat);
  endfunction

endpackage

// File: rtl/fsb_addr_gen.sv
module fsb_addr_gen
  import fsb_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              advance,
  input  logic              interleave,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] acc_addr
);

  localparam int BEAT_W = 2;

  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] beat_nxt;

  assign beat_nxt = beat_q + 2'd1;

  // A load uses the external address directly; a continue uses the next beat.
  assign acc_addr = load ? addr_in
                         : {base_q[ADDR_W-1:BEAT_W],
                            beat_offset(base_q[BEAT_W-1:0], beat_nxt, interleave)};

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      beat_q <= '0;
    end else if (load) begin
      base_q <= addr_in;
      beat_q <= '0;
    end else if (advance) begin
      beat_q <= beat_nxt;
    end
  end

  // R5: the start address is kept while a burst advances
  a_r5_base_held: assert property (@(posedge clk) disable iff (rst)
    (advance && !load) |=> $stable(base_q));

endmodule

// File: rtl/fsb_cmd_ctrl.sv
module fsb_cmd_ctrl
  import fsb_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en_n,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              burst_next,
  input  logic              wr_n,
  input  logic              sleep_req,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              load,
  output logic              advance,
  output logic              rd_fire,
  output logic              wr_fire,
  output logic              asleep,
  output logic              rd_valid,
  output logic              wr_pend,
  output logic [ADDR_W-1:0] wr_addr
);

  fsb_op_e op_q, op_nxt;
  logic    sleep_s1_q, asleep_q;
  logic    rd_valid_q, wr_pend_q;
  logic    live, selected;

  assign live     = !clk_en_n && !asleep_q;
  assign selected = !sel_a_n && sel_b && !sel_c_n;

  always_comb begin
    op_nxt  = op_q;
    load    = 1'b0;
    advance = 1'b0;
    if (!burst_next) begin
      if (selected) begin
        op_nxt = wr_n ? OP_READ : OP_WRITE;
        load   = live;
      end else begin
        op_nxt = OP_IDLE;
      end
    end else if (op_q != OP_IDLE) begin
      advance = live;
    end
  end

  assign wr_fire = live && wr_pend_q;
  assign rd_fire = live && (op_nxt == OP_READ);

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q       <= OP_IDLE;
      wr_pend_q  <= 1'b0;
      rd_valid_q <= 1'b0;
      sleep_s1_q <= 1'b0;
      asleep_q   <= 1'b0;
      wr_addr    <= '0;
    end else begin
      sleep_s1_q <= sleep_req;
      asleep_q   <= sleep_s1_q;
      if (asleep_q) begin
        op_q       <= OP_IDLE;
        wr_pend_q  <= 1'b0;
        rd_valid_q <= 1'b0;
      end else if (!clk_en_n) begin
        op_q       <= op_nxt;
        wr_pend_q  <= (op_nxt == OP_WRITE);
        rd_valid_q <= (op_nxt == OP_READ);
        if (op_nxt == OP_WRITE) wr_addr <= acc_addr;
      end
    end
  end

  assign asleep   = asleep_q;
  assign rd_valid = rd_valid_q;
  assign wr_pend  = wr_pend_q;

  // R8: a frozen edge leaves all command state untouched
  a_r8_stall_holds: assert property (@(posedge clk) disable iff (rst)
    (clk_en_n && !asleep_q) |=> ($stable(op_q) && $stable(wr_pend_q) && $stable(rd_valid_q)));

  // R10: sleep cancels any pending access and parks the block deselected
  a_r10_sleep_idles: assert property (@(posedge clk) disable iff (rst)
    asleep_q |=> (op_q == OP_IDLE && !wr_pend_q && !rd_valid_q));

  // R5: a continue edge keeps the access type of the running burst
  a_r5_type_kept: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && !asleep_q && burst_next && op_q != OP_IDLE) |=> (op_q == $past(op_q)));

  // R1: the first cycle after reset is idle
  a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (op_q == OP_IDLE && !rd_valid_q && !wr_pend_q));

endmodule

// File: rtl/fsb_lane_ram.sv
module fsb_lane_ram #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [LANE_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [LANE_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem [DEPTH];

  // Simple dual-port, read-first: maps onto a block RAM lane.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/fsb_sram.sv
module fsb_sram
  import fsb_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clk_en_n,
  input  logic                       sel_a_n,
  input  logic                       sel_b,
  input  logic                       sel_c_n,
  input  logic                       burst_next,
  input  logic                       wr_n,
  input  logic [DATA_W/LANE_W-1:0]   lane_wr_n,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  input  logic                       out_en_n,
  input  logic                       order_ilv,
  input  logic                       sleep_req,
  output logic [DATA_W-1:0]          rdata,
  output logic                       rdata_oe
);

  localparam int LANES = DATA_W / LANE_W;

  logic              load, advance, rd_fire, wr_fire;
  logic              asleep, rd_valid, wr_pend;
  logic [ADDR_W-1:0] acc_addr, wr_addr;
  logic [DATA_W-1:0] ram_q;
  logic [LANES-1:0]  lane_we;

  logic              fwd_hit_q;
  logic [LANES-1:0]  fwd_mask_q;
  logic [DATA_W-1:0] fwd_data_q;

  fsb_cmd_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .clk_en_n(clk_en_n),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .burst_next(burst_next), .wr_n(wr_n), .sleep_req(sleep_req),
    .acc_addr(acc_addr),
    .load(load), .advance(advance), .rd_fire(rd_fire), .wr_fire(wr_fire),
    .asleep(asleep), .rd_valid(rd_valid), .wr_pend(wr_pend), .wr_addr(wr_addr)
  );

  fsb_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst(rst), .load(load), .advance(advance),
    .interleave(order_ilv), .addr_in(addr), .acc_addr(acc_addr)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_we[g] = wr_fire && !lane_wr_n[g];

    fsb_lane_ram #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_ram (
      .clk(clk), .we(lane_we[g]), .waddr(wr_addr),
      .wdata(wdata[g*LANE_W +: LANE_W]),
      .re(rd_fire), .raddr(acc_addr),
      .rdata(ram_q[g*LANE_W +: LANE_W])
    );

    // Lanes committed on the same edge as the read come from the forward path.
    assign rdata[g*LANE_W +: LANE_W] = (fwd_hit_q && fwd_mask_q[g])
                                       ? fwd_data_q[g*LANE_W +: LANE_W]
                                       : ram_q[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_hit_q  <= 1'b0;
      fwd_mask_q <= '0;
      fwd_data_q <= '0;
    end else if (rd_fire) begin
      fwd_hit_q  <= wr_fire && (wr_addr == acc_addr);
      fwd_mask_q <= ~lane_wr_n;
      fwd_data_q <= wdata;
    end
  end

  assign rdata_oe = rd_valid && !out_en_n && !asleep;

  // R9: never drive while write data is expected on the bus
  a_r9_quiet_write_phase: assert property (@(posedge clk) disable iff (rst)
    wr_pend |-> !rdata_oe);

endmodule

// File: tb/fsb_sram_tb.sv
module fsb_sram_tb;
  localparam int AW = 6;
  localparam int DW = 32;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clk_en_n = 1'b1, sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
  logic burst_next = 1'b0, wr_n = 1'b1, out_en_n = 1'b0, order_ilv = 1'b0, sleep_req = 1'b0;
  logic [3:0] lane_wr_n = 4'hF;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rdata_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  logic [DW-1:0] m_mem [DEPTH];
  int            m_op = 0;
  logic [AW-1:0] m_base = '0, m_waddr = '0;
  logic [1:0]    m_cnt = '0;
  bit            m_wpend = 0, m_rvalid = 0, m_s1 = 0, m_asleep = 0;
  logic [DW-1:0] m_rdata = '0;

  always #2.5 clk = ~clk;

  fsb_sram #(.ADDR_W(AW), .DATA_W(DW), .LANE_W(8)) u_dut (
    .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .burst_next(burst_next), .wr_n(wr_n), .lane_wr_n(lane_wr_n),
    .addr(addr), .wdata(wdata), .out_en_n(out_en_n), .order_ilv(order_ilv),
    .sleep_req(sleep_req), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  function automatic logic [DW-1:0] pat(input int a);
    return 32'h1000_0000 + a * 32'h0001_0003;
  endfunction

  function automatic logic [1:0] order(input logic [1:0] lo, input logic [1:0] i, input logic ilv);
    return ilv ? (lo ^ i) : 2'(lo + i);
  endfunction

  task automatic chk32(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk1(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // sel code: 0 all active, 1..3 one select inactive
  task automatic cmd(input int selc, input bit nxt, input bit wn, input logic [3:0] bw,
                     input int a, input logic [DW-1:0] d);
    clk_en_n   = 1'b0;
    sel_a_n    = (selc == 1);
    sel_b      = (selc != 2);
    sel_c_n    = (selc == 3);
    burst_next = nxt;
    wr_n       = wn;
    lane_wr_n  = bw;
    addr       = AW'(a);
    wdata      = d;
  endtask

  task automatic model_edge();
    bit a_old;
    bit sel;
    logic [AW-1:0] acc;
    a_old    = m_asleep;
    m_asleep = m_s1;
    m_s1     = sleep_req;
    acc      = '0;
    if (a_old) begin
      m_op = 0; m_wpend = 0; m_rvalid = 0;
    end else if (!clk_en_n) begin
      if (m_wpend)
        for (int b = 0; b < 4; b++)
          if (!lane_wr_n[b]) m_mem[m_waddr][8*b +: 8] = wdata[8*b +: 8];
      sel = !sel_a_n && sel_b && !sel_c_n;
      if (!burst_next) begin
        if (sel) begin
          m_op = wr_n ? 1 : 2; m_base = addr; m_cnt = 0; acc = addr;
        end else m_op = 0;
      end else if (m_op != 0) begin
        m_cnt = m_cnt + 2'd1;
        acc = {m_base[AW-1:2], order(m_base[1:0], m_cnt, order_ilv)};
      end
      m_wpend  = (m_op == 2);
      if (m_wpend) m_waddr = acc;
      m_rvalid = (m_op == 1);
      if (m_rvalid) m_rdata = m_mem[acc];
    end
  endtask

  // one clock: edge, model update, compare 1 ns later
  task automatic tick(input string tag);
    bit exp_oe;
    @(posedge clk);
    model_edge();
    #1;
    exp_oe = m_rvalid && !out_en_n && !m_asleep;
    chk1({tag, " drive"}, rdata_oe, exp_oe);
    if (exp_oe) chk32({tag, " data"}, rdata, m_rdata);
  endtask

  task automatic stall(input string tag);
    clk_en_n = 1'b1;
    wdata = $urandom;
    tick(tag);
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd7321);
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;

    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    clk_en_n = 1'b0;
    #1;
    chk1("R1 reset drive", rdata_oe, 1'b0);
    cmd(0, 1, 1, 4'hF, 0, 0); tick("R1 continue deselect");
    chk1("R1 continued deselect quiet", rdata_oe, 1'b0);

    // preload every word with linear aligned bursts
    for (int j = 0; j <= DEPTH; j++) begin
      if (j == DEPTH) cmd(2, 0, 0, 4'h0, 0, pat(j - 1));
      else if (j % 4 == 0) cmd(0, 0, 0, 4'h0, j, (j == 0) ? 32'h0 : pat(j - 1));
      else cmd(1, 1, 1, 4'h0, 0, pat(j - 1));
      tick("R5 preload");
    end

    // linear burst from 1: 1,2,3,0; continue with selects off and wr_n low
    order_ilv = 1'b0;
    cmd(0, 0, 1, 4'hF, 1, 0); tick("R4 read");
    chk32("R6 linear beat0", rdata, pat(1));
    cmd(3, 1, 0, 4'h0, 9, 0); tick("R5 cont");
    chk32("R6 linear beat1", rdata, pat(2));
    cmd(1, 1, 0, 4'h0, 9, 0); tick("R5 cont");
    chk32("R6 linear beat2", rdata, pat(3));
    cmd(2, 1, 0, 4'h0, 9, 0); tick("R5 cont");
    chk32("R5 wrap linear beat3", rdata, pat(0));
    cmd(1, 0, 1, 4'hF, 0, 0); tick("R2 deselect");
    chk1("R2 deselect quiet", rdata_oe, 1'b0);

    // interleaved burst from 9: 9,8,11,10
    order_ilv = 1'b1;
    cmd(0, 0, 1, 4'hF, 9, 0); tick("R4 read");
    chk32("R6 ilv beat0", rdata, pat(9));
    cmd(2, 1, 0, 4'h0, 0, 0); tick("R5 cont");
    chk32("R6 ilv beat1", rdata, pat(8));
    cmd(2, 1, 0, 4'h0, 0, 0); tick("R5 cont");
    chk32("R6 ilv beat2", rdata, pat(11));
    cmd(2, 1, 0, 4'h0, 0, 0); tick("R5 cont");
    chk32("R6 ilv beat3", rdata, pat(10));
    cmd(3, 0, 1, 4'hF, 0, 0); tick("R2 deselect");
    order_ilv = 1'b0;

    // write then read the same address back to back
    cmd(0, 0, 0, 4'h0, 10, 0); tick("R9 write phase");
    chk1("R9 write phase quiet", rdata_oe, 1'b0);
    cmd(0, 0, 1, 4'h0, 10, 32'hDEAD_BEEF); tick("R3 fwd");
    chk32("R3 read after write", rdata, 32'hDEAD_BEEF);
    // partial lanes 0 and 2
    cmd(0, 0, 0, 4'hF, 11, 0); tick("R7 write");
    cmd(0, 0, 1, 4'b1010, 11, 32'h1122_3344); tick("R7 fwd");
    chk32("R7 lane merge", rdata, {pat(11)[31:24], 8'h22, pat(11)[15:8], 8'h44});

    // burst write with aborted middle beat
    cmd(0, 0, 0, 4'h0, 20, 0); tick("R7 burst");
    cmd(0, 1, 1, 4'h0, 0, 32'hAAAA_0020); tick("R7 burst");
    cmd(0, 1, 1, 4'hF, 0, 32'hBBBB_0021); tick("R7 abort");
    cmd(2, 0, 1, 4'h0, 0, 32'hCCCC_0022); tick("R7 last");
    cmd(0, 0, 1, 4'hF, 21, 0); tick("R7 read");
    chk32("R7 aborted lane kept", rdata, pat(21));
    cmd(0, 0, 1, 4'hF, 22, 0); tick("R7 read");
    chk32("R7 beat after abort", rdata, 32'hCCCC_0022);

    // stall in the write data phase
    cmd(0, 0, 0, 4'h0, 30, 0); tick("R8 write");
    repeat (3) stall("R8 stall");
    cmd(0, 0, 1, 4'h0, 30, 32'hCAFE_F00D); tick("R8 late data");
    chk32("R8 data after stall", rdata, 32'hCAFE_F00D);
    cmd(0, 0, 1, 4'hF, 31, 0); tick("R4 read");
    repeat (2) stall("R8 hold");
    chk1("R8 drive held", rdata_oe, 1'b1);
    chk32("R8 data held", rdata, pat(31));

    // asynchronous output enable
    cmd(0, 0, 1, 4'hF, 6, 0); tick("R4 read");
    out_en_n = 1'b1; #0.5;
    chk1("R9 oe high off", rdata_oe, 1'b0);
    out_en_n = 1'b0; #0.5;
    chk1("R9 oe low on", rdata_oe, 1'b1);
    chk32("R4 read data", rdata, pat(6));

    // sleep entry, ignored commands, retention, wake
    sleep_req = 1'b1;
    cmd(2, 0, 1, 4'hF, 0, 0); tick("R10 e0");
    cmd(0, 0, 1, 4'hF, 41, 0); tick("R10 e1");
    chk1("R10 off after e1", rdata_oe, 1'b0);
    repeat (3) begin cmd(0, 0, 0, 4'h0, 40, 32'h0BAD_0BAD); tick("R10 ignored write"); end
    cmd(0, 0, 1, 4'hF, 41, 0); tick("R10 ignored read");
    chk1("R10 asleep quiet", rdata_oe, 1'b0);
    sleep_req = 1'b0;
    cmd(0, 1, 1, 4'h0, 0, 0); tick("R10 wake");
    cmd(0, 1, 1, 4'h0, 0, 0); tick("R10 wake");
    cmd(0, 1, 1, 4'h0, 0, 0); tick("R1 still deselected");
    chk1("R10 deselected after wake", rdata_oe, 1'b0);
    cmd(0, 0, 1, 4'hF, 40, 0); tick("R10 read");
    chk32("R10 contents kept", rdata, pat(40));

    // constrained random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom % 16;
      out_en_n = (($urandom % 8) == 0);
      if (n % 250 == 0) order_ilv = $urandom;
      if (n % 400 == 390) sleep_req = 1'b1;
      if (n % 400 == 398) sleep_req = 1'b0;
      if (r < 6)       cmd(0, 0, 1, 4'($urandom), $urandom % DEPTH, $urandom);
      else if (r < 11) cmd(0, 0, 0, 4'($urandom), $urandom % DEPTH, $urandom);
      else if (r < 13) cmd($urandom % 4, 1, $urandom, 4'($urandom), $urandom % DEPTH, $urandom);
      else if (r < 14) cmd(1 + $urandom % 3, 0, $urandom, 4'($urandom), 0, $urandom);
      else begin
        cmd(0, $urandom, $urandom, 4'($urandom), $urandom % DEPTH, $urandom);
        clk_en_n = 1'b1;
      end
      tick("R4 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule